// File: doc/BRIEF.md
# SPI Slave Byte Shifter

This block is the receive and transmit datapath of a serial-peripheral slave. It runs entirely on the system clock. The serial clock, the serial data input and the active-low select arrive asynchronously. Each one passes through a two-stage synchronizer. The block then finds edges of the serial clock by comparing the synchronized value with its value one cycle earlier. Each byte is eight bits wide. While it shifts out a transmit byte that was loaded beforehand on the serial output, it collects the bits arriving on the serial input.

Three static configuration inputs set the transfer format: the idle level of the serial clock, the clock phase, and whether the first bit on the wire is the least significant bit. A falling select starts a byte. In phase 1 the master may send further bytes with select held low. A rising select in the middle of a byte discards that byte. After each full byte the block latches the received value, pulses a done strobe for one cycle and loads the next transmit byte. The serial clock must stay at each level for at least four system-clock cycles.

Top module: `spi_slave_core`

## Requirements
- R1: After reset, `miso_oe`, `miso_out` and `rx_done` are 0 and `rx_byte` is 0x00.
- R2: `miso_oe` is 1 while select is low and 0 after select returns high. `miso_out` is 0 whenever `miso_oe` is 0.
- R3: With `cfg_cpha`=0, the first bit of the transmit byte is on `miso_out` before the first serial-clock edge. Data is sampled on leading edges, and the next bit is presented on trailing edges.
- R4: With `cfg_cpha`=1, `miso_oe` goes to 1 when select falls. Each leading edge presents the next bit on `miso_out`, and each trailing edge samples the input.
- R5: `cfg_cpol` gives the idle level of the serial clock. A leading edge is a change away from that level, and a trailing edge is the return to it.
- R6: With `cfg_lsb_first`=0, bit 7 travels first. With `cfg_lsb_first`=1, bit 0 travels first. The same order applies to the transmitted byte and to the assembly of `rx_byte`.
- R7: After the eighth sample of a byte, `rx_byte` holds the received value and `rx_done` is 1 for exactly one cycle.
- R8: With `cfg_cpha`=1 and select held low, the byte after a completed one is transferred correctly. Its transmit data is the value of `tx_byte` at the moment the previous byte completed.
- R9: A rise of select before the eighth sample discards the partial byte without a `rx_done` pulse. The next select starts again at bit 0.
- R10: `tx_byte` is captured when select falls. Changing it afterwards does not alter the byte being sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Clock phase: 0 samples on leading edges, 1 samples on trailing edges |
| cfg_lsb_first | input | 1 | 1 sends and receives bit 0 first |
| tx_byte | input | 8 | Next byte to transmit |
| sclk_in | input | 1 | Serial clock from master (asynchronous) |
| mosi_in | input | 1 | Serial data from master (asynchronous) |
| ssel_n_in | input | 1 | Active-low slave select (asynchronous) |
| miso_out | output | 1 | Serial data to master |
| miso_oe | output | 1 | Output enable for `miso_out` |
| rx_byte | output | 8 | Last completed received byte |
| rx_done | output | 1 | One-cycle strobe when a byte completes |

## Verification
The bound checker enforces several properties on every cycle. The output enable follows the synchronized select. The serial output stays quiet while it is released. The done strobe lasts one cycle, appears only while the slave is selected, and appears only when the bit counter sits on its last position. What a property cannot express is the data content. The directed scenarios cover the bit order, the phase-dependent moment each bit appears, the reload between back-to-back bytes, and the recovery after an aborted byte. The bench checks each of these by playing master and comparing the shifted data in both directions.

// File: rtl/spi_slv_pkg.sv
// Shared types for the SPI slave shifter.
// Assumes: configuration inputs are static while a byte is in flight.
package spi_slv_pkg;

    // Transfer format selected by the configuration pins
    typedef struct packed {
        logic cpol;
        logic cpha;
        logic lsb_first;
    } spi_fmt_t;

endpackage

// File: rtl/spi_slv_sync.sv
// Multi-bit synchronizer: every input bit passes through STAGES flops.
// Assumes: bits are independent (no multi-bit coherence is needed).
module spi_slv_sync #(
    parameter int WIDTH     = 3,
    parameter int STAGES    = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // first flop captures the asynchronous input
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[0] <= RST_VAL;
                else        stage_q[0] <= d_async;
            end
        end else begin : g_rest
            // later flops resolve metastability
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= RST_VAL;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/spi_slv_edge.sv
// Serial clock edge finder: flags leading (away from idle) and trailing
// (back to idle) edges of the synchronized serial clock.
// Assumes: the serial clock holds each level for several system cycles.
module spi_slv_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_s,
    input  logic cpol,
    output logic lead,
    output logic trail
);
    logic sclk_prev;

    // remember last synchronized clock level
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_prev <= 1'b0;
        else        sclk_prev <= sclk_s;
    end

    // a change is leading when it leaves the idle level
    always_comb begin
        lead  = (sclk_s != sclk_prev) && (sclk_s != cpol);
        trail = (sclk_s != sclk_prev) && (sclk_s == cpol);
    end
endmodule

// File: rtl/spi_slv_shifter.sv
// Byte engine: bit counter, transmit and receive shift registers, select
// driven start and abort, done strobe and transmit reload.
// Assumes: lead and trail are single-cycle and never coincide.
module spi_slv_shifter
    import spi_slv_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int CW    = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  spi_fmt_t          fmt,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              mosi_s,
    input  logic              sel_act,
    input  logic              lead,
    input  logic              trail,
    output logic              miso_out,
    output logic              miso_oe,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_done,
    output logic [CW-1:0]     bit_cnt
);
    localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

    logic [DATA_W-1:0] tx_sh, rx_sh, rx_next;
    logic              miso_q, active;
    logic              present_ev, sample_ev;

    // bit that leaves the shifter next, by order setting
    function automatic logic head_bit(input logic [DATA_W-1:0] v, input logic lsb);
        return lsb ? v[0] : v[DATA_W-1];
    endfunction

    // shifter contents after one bit has left
    function automatic logic [DATA_W-1:0] advance(input logic [DATA_W-1:0] v, input logic lsb);
        return lsb ? {1'b0, v[DATA_W-1:1]} : {v[DATA_W-2:0], 1'b0};
    endfunction

    // phase picks which edge presents and which samples
    always_comb begin
        present_ev = fmt.cpha ? lead  : trail;
        sample_ev  = fmt.cpha ? trail : lead;
        rx_next    = fmt.lsb_first ? {mosi_s, rx_sh[DATA_W-1:1]}
                                   : {rx_sh[DATA_W-2:0], mosi_s};
    end

    // byte sequencing: start, shift, sample, complete, abort
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            miso_q  <= 1'b0;
            tx_sh   <= '0;
            rx_sh   <= '0;
            rx_byte <= '0;
            rx_done <= 1'b0;
            bit_cnt <= '0;
        end else begin
            rx_done <= 1'b0;
            active  <= sel_act;
            if (!sel_act) begin
                bit_cnt <= '0;
                rx_sh   <= '0;
                miso_q  <= 1'b0;
            end else if (!active) begin
                bit_cnt <= '0;
                rx_sh   <= '0;
                if (fmt.cpha) begin
                    tx_sh  <= tx_byte;
                    miso_q <= 1'b0;
                end else begin
                    miso_q <= head_bit(tx_byte, fmt.lsb_first);
                    tx_sh  <= advance(tx_byte, fmt.lsb_first);
                end
            end else begin
                if (present_ev) begin
                    miso_q <= head_bit(tx_sh, fmt.lsb_first);
                    tx_sh  <= advance(tx_sh, fmt.lsb_first);
                end
                if (sample_ev) begin
                    rx_sh <= rx_next;
                    if (bit_cnt == LAST) begin
                        bit_cnt <= '0;
                        rx_byte <= rx_next;
                        rx_done <= 1'b1;
                        tx_sh   <= tx_byte;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
            end
        end
    end

    assign miso_oe  = active;
    assign miso_out = miso_q;
endmodule

// File: rtl/spi_slave_core.sv
// SPI slave top: synchronizes the serial pins, finds clock edges and runs
// the byte shifter. Assumes each serial clock level lasts >= 4 clk cycles.
module spi_slave_core
    import spi_slv_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    localparam int CW         = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              cfg_lsb_first,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              sclk_in,
    input  logic              mosi_in,
    input  logic              ssel_n_in,
    output logic              miso_out,
    output logic              miso_oe,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_done
);
    logic [2:0]    pins_s;
    logic          lead_w, trail_w, sel_act_w;
    logic [CW-1:0] bit_cnt_w;
    spi_fmt_t      fmt;

    // pack configuration into the shared format type
    always_comb begin
        fmt.cpol      = cfg_cpol;
        fmt.cpha      = cfg_cpha;
        fmt.lsb_first = cfg_lsb_first;
    end

    spi_slv_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({ssel_n_in, mosi_in, sclk_in}),
        .q_sync  (pins_s)
    );

    assign sel_act_w = ~pins_s[2];

    spi_slv_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sclk_s(pins_s[0]),
        .cpol  (cfg_cpol),
        .lead  (lead_w),
        .trail (trail_w)
    );

    spi_slv_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .fmt     (fmt),
        .tx_byte (tx_byte),
        .mosi_s  (pins_s[1]),
        .sel_act (sel_act_w),
        .lead    (lead_w),
        .trail   (trail_w),
        .miso_out(miso_out),
        .miso_oe (miso_oe),
        .rx_byte (rx_byte),
        .rx_done (rx_done),
        .bit_cnt (bit_cnt_w)
    );
endmodule

// File: rtl/spi_slave_core_chk.sv
// Cycle-level rules for the SPI slave, bound to the top module.
// Assumes: observes only, drives nothing.
module spi_slave_core_chk #(
    parameter int CW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sel_act,
    input logic          miso_oe,
    input logic          miso_out,
    input logic          rx_done,
    input logic [CW-1:0] bit_cnt
);
    localparam logic [CW-1:0] LAST = {CW{1'b1}};

    AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_act |=> !miso_oe);                                      // R2
    AST_OE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        sel_act |=> miso_oe);                                        // R4
    AST_QUIET_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !miso_oe |-> !miso_out);                                     // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> !rx_done);                                       // R7
    AST_DONE_LAST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |-> ($past(bit_cnt) == LAST && bit_cnt == '0));      // R7
    AST_DONE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |-> miso_oe);                                        // R9
endmodule

bind spi_slave_core spi_slave_core_chk #(.CW(CW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_act (sel_act_w),
    .miso_oe (miso_oe),
    .miso_out(miso_out),
    .rx_done (rx_done),
    .bit_cnt (bit_cnt_w)
);

// File: tb/spi_slave_core_test.sv
module spi_slave_core_test;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_lsb_first = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic       sclk_in = 1'b0, mosi_in = 1'b0, ssel_n_in = 1'b1;
    logic       miso_out, miso_oe, rx_done;
    logic [7:0] rx_byte;

    int total = 0, bad = 0, done_seen = 0;
    logic [7:0] got_rx = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_slave_core uut (
        .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .cfg_lsb_first(cfg_lsb_first), .tx_byte(tx_byte), .sclk_in(sclk_in),
        .mosi_in(mosi_in), .ssel_n_in(ssel_n_in), .miso_out(miso_out),
        .miso_oe(miso_oe), .rx_byte(rx_byte), .rx_done(rx_done)
    );

    // count done strobes cycle by cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n && rx_done) begin
            done_seen++;
            got_rx = rx_byte;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_mode(input logic cp, input logic ph, input logic lf);
        ssel_n_in = 1'b1;
        cfg_cpol = cp; cfg_cpha = ph; cfg_lsb_first = lf;
        sclk_in = cp;
        wait_clks(8);
    endtask

    // play master for nbits; collect miso bits into a byte
    task automatic xfer(input logic [7:0] mo, output logic [7:0] mi, input int nbits);
        mi = 8'h00;
        for (int i = 0; i < nbits; i++) begin
            logic b, m;
            b = cfg_lsb_first ? mo[i] : mo[7-i];
            if (!cfg_cpha) begin
                mosi_in = b;
                wait_clks(2);
                m = miso_out;
                sclk_in = ~cfg_cpol;
                wait_clks(HALF);
                sclk_in = cfg_cpol;
                wait_clks(HALF);
            end else begin
                sclk_in = ~cfg_cpol;
                mosi_in = b;
                wait_clks(HALF);
                m = miso_out;
                sclk_in = cfg_cpol;
                wait_clks(HALF);
            end
            if (cfg_lsb_first) mi[i] = m;
            else               mi = {mi[6:0], m};
        end
    endtask

    task automatic t_reset();
        check(miso_oe == 1'b0, "R1", "oe after reset", miso_oe, 0);
        check(miso_out == 1'b0, "R1", "miso after reset", miso_out, 0);
        check(rx_done == 1'b0, "R1", "done after reset", rx_done, 0);
        check(rx_byte == 8'h00, "R1", "rx_byte after reset", rx_byte, 0);
    endtask

    // one full byte in a given format; checks both directions
    task automatic t_byte(input logic cp, input logic ph, input logic lf,
                          input logic [7:0] tx, input logic [7:0] mo, input string req);
        logic [7:0] mi;
        int d0;
        set_mode(cp, ph, lf);
        tx_byte = tx;
        d0 = done_seen;
        ssel_n_in = 1'b0;
        wait_clks(HALF);
        check(miso_oe == 1'b1, "R2", "oe while selected", miso_oe, 1);
        if (!ph) check(miso_out == (lf ? tx[0] : tx[7]), "R3", "first bit before edge",
                       miso_out, lf ? tx[0] : tx[7]);
        xfer(mo, mi, 8);
        check(mi == tx, req, "miso byte", mi, tx);
        check(got_rx == mo, "R6", "rx byte order", got_rx, mo);
        check(done_seen == d0 + 1, "R7", "single done pulse", done_seen - d0, 1);
        ssel_n_in = 1'b1;
        wait_clks(HALF);
        check(miso_oe == 1'b0, "R2", "oe after deselect", miso_oe, 0);
        check(miso_out == 1'b0, "R2", "miso quiet released", miso_out, 0);
    endtask

    // phase 1, two bytes with select held low
    task automatic t_back_to_back();
        logic [7:0] mi1, mi2;
        int d0;
        set_mode(1'b0, 1'b1, 1'b0);
        tx_byte = 8'hC3;
        d0 = done_seen;
        ssel_n_in = 1'b0;
        wait_clks(HALF);
        check(miso_oe == 1'b1, "R4", "oe at select, phase 1", miso_oe, 1);
        tx_byte = 8'h5E;
        xfer(8'h81, mi1, 8);
        check(mi1 == 8'hC3, "R10", "tx captured at select", mi1, 8'hC3);
        check(got_rx == 8'h81, "R8", "first rx", got_rx, 8'h81);
        tx_byte = 8'h00;
        xfer(8'h3C, mi2, 8);
        check(mi2 == 8'h5E, "R8", "reloaded tx", mi2, 8'h5E);
        check(got_rx == 8'h3C, "R8", "second rx", got_rx, 8'h3C);
        check(done_seen == d0 + 2, "R8", "two done pulses", done_seen - d0, 2);
        ssel_n_in = 1'b1;
        wait_clks(HALF);
    endtask

    // select rises after 3 bits; next byte starts clean
    task automatic t_abort();
        logic [7:0] mi;
        int d0;
        set_mode(1'b0, 1'b0, 1'b0);
        tx_byte = 8'h96;
        d0 = done_seen;
        ssel_n_in = 1'b0;
        wait_clks(HALF);
        xfer(8'hFF, mi, 3);
        ssel_n_in = 1'b1;
        wait_clks(HALF);
        check(miso_oe == 1'b0, "R9", "oe after abort", miso_oe, 0);
        check(done_seen == d0, "R9", "no done on abort", done_seen - d0, 0);
        tx_byte = 8'h2D;
        ssel_n_in = 1'b0;
        wait_clks(HALF);
        xfer(8'h47, mi, 8);
        check(mi == 8'h2D, "R9", "tx restarts at bit 0", mi, 8'h2D);
        check(got_rx == 8'h47, "R9", "rx restarts at bit 0", got_rx, 8'h47);
        check(done_seen == d0 + 1, "R9", "one done after restart", done_seen - d0, 1);
        ssel_n_in = 1'b1;
        wait_clks(HALF);
    endtask

    initial begin
        wait_clks(4);
        rst_n = 1'b1;
        wait_clks(2);
        t_reset();
        t_byte(1'b0, 1'b0, 1'b0, 8'hA5, 8'h3C, "R3");
        t_byte(1'b1, 1'b0, 1'b0, 8'h1F, 8'hE2, "R5");
        t_byte(1'b0, 1'b1, 1'b0, 8'h6B, 8'h90, "R4");
        t_byte(1'b1, 1'b1, 1'b1, 8'h81, 8'h7E, "R6");
        t_byte(1'b0, 1'b0, 1'b1, 8'h34, 8'hC9, "R6");
        t_back_to_back();
        t_abort();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule